// File: doc/BRIEF.md
# Inter-Core Mailbox Interrupt Controller

This block lets any core of a multi-core cluster post a 16-bit message and an interrupt to any core, including itself. Every core owns an 8-byte slot in a small register window. The lower word is a command word the core writes to send or to acknowledge. The upper word is a mailbox the core reads to find who signalled it and with what payload.

A send is one full-word write to the sender's own command word. The write sets the send bit, names the target core and carries the payload. The target's mailbox latches the sender number and the payload, and the target's interrupt line goes high. The line stays high until the target writes the acknowledge bit to its own command word. The block has no interrupt inputs. There is one level interrupt output per core. The bus side is a single-cycle 32-bit register slave with full-word accesses only.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: Core n's command word is at byte address n*8 and its mailbox at n*8+4. Address bit 2 selects the mailbox, address bits [1:0] are ignored, and the core number is taken from the address bits above bit 2.
- R2: A write to core s's command word with bit 30 (send) set and a target t in bits 29:16 with t < NCORES makes core t's mailbox read, from the next cycle, bit 30 = 1, bits 29:16 = s and bits 15:0 = the payload from bits 15:0 of the write.
- R3: irq_o[n] is high exactly while core n's mailbox pending bit (bit 30) is set, and it holds its value across cycles with no bus write.
- R4: A write to core n's command word with bit 31 (acknowledge) set clears core n's pending bit, source and payload from the next cycle. Other cores' mailboxes are not affected.
- R5: A send whose target field (bits 29:16) is NCORES or above changes no mailbox and no interrupt.
- R6: A send to a core that is already pending keeps it pending and replaces the source and payload with those of the newest send.
- R7: When one write sets both acknowledge and send, the acknowledge of the writer's mailbox is applied first and the send second. A core that sends to itself this way ends up pending with the new message.
- R8: Reads of any command word return zero, and bit 31 of a mailbox read is always zero.
- R9: Writes to a mailbox address change no mailbox and no interrupt.
- R10: Reset clears every pending bit, source and payload, and drives all interrupt outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address within the window (AW = log2(NCORES)+3) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | NCORES | Level interrupt, one per core |

## Verification
The bench targets the orderings that a simple design is likely to get wrong. It sends to a core that is already pending; a design that kept the first message there would return the stale sender and payload. It sends with acknowledge and send together, both to the writer itself and to another core. A design that applied the acknowledge last would lose a message to self, and one that routed the acknowledge to the target would clear the wrong mailbox. It sends to targets past the last core and writes to mailbox addresses. A design that decoded only the low bits of the target, or that did not reject mailbox writes, would raise or corrupt an interrupt there.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int IDW       = 14;  // core-number field width
  localparam int PLW       = 16;  // payload width
  localparam int ACK_BIT   = 31;
  localparam int SEND_BIT  = 30;
  localparam int TGT_LO    = 16;
  localparam int TGT_HI    = TGT_LO + IDW - 1;

  typedef struct packed {
    logic           pend;
    logic [IDW-1:0] src;
    logic [PLW-1:0] data;
  } mbox_t;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      s1_q    <= 1'b1;
      rst_q_n <= s1_q;
    end
  end
endmodule

// File: rtl/ipi_decode.sv
module ipi_decode #(
  parameter int NCORES = 4,
  parameter int AW     = $clog2(NCORES) + 3,
  parameter int CW     = AW - 3
) (
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  output logic          wr_cmd,
  output logic          rd_mbox,
  output logic [CW-1:0] slot,
  output logic          slot_ok
);
  logic is_mbox;

  always_comb begin
    is_mbox = bus_addr[2];
    slot    = bus_addr[AW-1:3];
    slot_ok = (32'(slot) < NCORES);
    wr_cmd  = bus_sel &&  bus_we && !is_mbox && slot_ok;
    rd_mbox = bus_sel && !bus_we &&  is_mbox && slot_ok;
  end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
  import ipi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack_i,
  input  logic           send_i,
  input  logic [IDW-1:0] src_i,
  input  logic [PLW-1:0] data_i,
  output mbox_t          mbox_o
);
  mbox_t mbox_d;
  logic  mbox_en;

  // acknowledge first, then delivery: a delivery in the same cycle wins
  always_comb begin
    mbox_en = ack_i | send_i;
    mbox_d  = mbox_o;
    if (ack_i) begin
      mbox_d = '0;
    end
    if (send_i) begin
      mbox_d.pend = 1'b1;
      mbox_d.src  = src_i;
      mbox_d.data = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbox_o <= '0;
    end else if (mbox_en) begin
      mbox_o <= mbox_d;
    end
  end
endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
  import ipi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = $clog2(NCORES) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCORES-1:0] irq_o
);
  localparam int CW = AW - 3;

  logic           rst_q_n;
  logic           wr_cmd;
  logic           rd_mbox;
  logic [CW-1:0]  slot;
  logic           slot_ok;
  logic [IDW-1:0] tgt;
  mbox_t          mbox [NCORES];
  logic [NCORES-1:0] ack_v;
  logic [NCORES-1:0] send_v;

  ipi_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ipi_decode #(.NCORES(NCORES), .AW(AW), .CW(CW)) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_cmd   (wr_cmd),
    .rd_mbox  (rd_mbox),
    .slot     (slot),
    .slot_ok  (slot_ok)
  );

  assign tgt = bus_wdata[TGT_HI:TGT_LO];

  for (genvar k = 0; k < NCORES; k++) begin : g_slot
    assign ack_v[k]  = wr_cmd && (slot == CW'(k)) && bus_wdata[ACK_BIT];
    assign send_v[k] = wr_cmd && (tgt == IDW'(k)) && bus_wdata[SEND_BIT];

    ipi_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .ack_i  (ack_v[k]),
      .send_i (send_v[k]),
      .src_i  (IDW'(slot)),
      .data_i (bus_wdata[PLW-1:0]),
      .mbox_o (mbox[k])
    );

    assign irq_o[k] = mbox[k].pend;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_mbox && slot_ok) begin
      bus_rdata = {1'b0, mbox[slot]};
    end
  end
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk #(
  parameter int NCORES = 4,
  parameter int AW     = $clog2(NCORES) + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NCORES-1:0] irq_o
);
  logic              cmd_wr;
  logic              mbox_wr;
  logic              rd_cmd;
  logic              rd_mb;
  logic [13:0]       tgt;
  logic              tgt_ok;
  logic [NCORES-1:0] own_mask;
  logic [NCORES-1:0] tgt_mask;

  always_comb begin
    cmd_wr   = bus_sel &&  bus_we && !bus_addr[2];
    mbox_wr  = bus_sel &&  bus_we &&  bus_addr[2];
    rd_cmd   = bus_sel && !bus_we && !bus_addr[2];
    rd_mb    = bus_sel && !bus_we &&  bus_addr[2];
    tgt      = bus_wdata[29:16];
    tgt_ok   = (32'(tgt) < NCORES);
    own_mask = NCORES'(1) << bus_addr[AW-1:3];
    tgt_mask = tgt_ok ? (NCORES'(1) << tgt) : '0;
  end

  assert_send_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[30] && tgt_ok) |=> ((irq_o & $past(tgt_mask)) != '0));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[31] && !bus_wdata[30]) |=> ((irq_o & $past(own_mask)) == '0));

  assert_self_send_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[31] && bus_wdata[30] && tgt_ok && (tgt_mask == own_mask))
      |=> ((irq_o & $past(own_mask)) != '0));

  assert_bad_target_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[30] && !bus_wdata[31] && !tgt_ok) |=> $stable(irq_o));

  assert_irq_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> $stable(irq_o));

  assert_mbox_pend_matches_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mb |-> (bus_rdata[30] == ((irq_o & own_mask) != '0)));

  assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |-> (bus_rdata == 32'h0));

  assert_reserved_bit_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mb |-> !bus_rdata[31]);

  assert_mbox_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_wr |=> $stable(irq_o));
endmodule

bind ipi_mailbox_ctrl ipi_mailbox_chk #(.NCORES(NCORES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o)
);

// File: tb/sim_ipi_mailbox_ctrl.sv
module sim_ipi_mailbox_ctrl;
  localparam int CLK_P  = 10;
  localparam int NCORES = 4;
  localparam int AW     = $clog2(NCORES) + 3;

  logic              clk;
  logic              rst_n;
  logic              bus_sel;
  logic              bus_we;
  logic [AW-1:0]     bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [NCORES-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ipi_mailbox_ctrl #(.NCORES(NCORES)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [AW-1:0] cmd_a(int n);
    return AW'(n * 8);
  endfunction
  function automatic logic [AW-1:0] mbox_a(int n);
    return AW'(n * 8 + 4);
  endfunction
  function automatic logic [31:0] cmd_w(bit ack, bit send, int tgt, logic [15:0] pl);
    return {ack, send, 14'(tgt), pl};
  endfunction
  function automatic logic [31:0] mbox_v(int src, logic [15:0] pl);
    return {1'b0, 1'b1, 14'(src), pl};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk_mbox(string req, int n, logic [31:0] exp);
    logic [31:0] d;
    rd(mbox_a(n), d);
    check(req, d, exp);
  endtask

  task automatic chk_irq(string req, logic [NCORES-1:0] exp);
    @(negedge clk);
    check(req, 32'(irq_o), 32'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    for (int n = 0; n < NCORES; n++) chk_mbox("R10 mailbox after reset", n, 32'h0);
    chk_irq("R10 irq after reset", '0);
  endtask

  task automatic t_basic_send();
    logic [31:0] d;
    wr(cmd_a(1), cmd_w(0, 1, 2, 16'hBEEF));
    chk_irq("R3 irq of target only", 4'b0100);
    chk_mbox("R2 mailbox of target", 2, mbox_v(1, 16'hBEEF));
    rd(mbox_a(2) | AW'(3), d);
    check("R1 low address bits ignored", d, mbox_v(1, 16'hBEEF));
    chk_mbox("R1 other mailbox untouched", 1, 32'h0);
    repeat (5) @(negedge clk);
    chk_irq("R3 irq holds while idle", 4'b0100);
  endtask

  task automatic t_overwrite();
    wr(cmd_a(3), cmd_w(0, 1, 2, 16'h1234));
    chk_mbox("R6 newest message kept", 2, mbox_v(3, 16'h1234));
    chk_irq("R6 still pending", 4'b0100);
  endtask

  task automatic t_ack();
    wr(cmd_a(3), cmd_w(0, 1, 0, 16'h0055));
    chk_irq("R2 second target pending", 4'b0101);
    wr(cmd_a(2), cmd_w(1, 0, 0, 16'h0));
    chk_irq("R4 ack clears own irq only", 4'b0001);
    chk_mbox("R4 acked mailbox cleared", 2, 32'h0);
    chk_mbox("R4 other mailbox kept", 0, mbox_v(3, 16'h0055));
  endtask

  task automatic t_bad_target();
    wr(cmd_a(0), cmd_w(0, 1, NCORES, 16'hAAAA));
    wr(cmd_a(1), cmd_w(0, 1, 14'h3FFF, 16'h5555));
    chk_irq("R5 out-of-range target ignored", 4'b0001);
    for (int n = 0; n < NCORES; n++)
      chk_mbox("R5 mailboxes unchanged", n, (n == 0) ? mbox_v(3, 16'h0055) : 32'h0);
  endtask

  task automatic t_ack_send();
    wr(cmd_a(0), cmd_w(1, 1, 0, 16'h7777));
    chk_mbox("R7 self send survives ack", 0, mbox_v(0, 16'h7777));
    chk_irq("R7 self send irq", 4'b0001);
    wr(cmd_a(0), cmd_w(1, 1, 1, 16'h0101));
    chk_mbox("R7 ack applied to writer", 0, 32'h0);
    chk_mbox("R7 send delivered to other core", 1, mbox_v(0, 16'h0101));
    chk_irq("R7 irq moved", 4'b0010);
  endtask

  task automatic t_reads();
    logic [31:0] d;
    for (int n = 0; n < NCORES; n++) begin
      rd(cmd_a(n), d);
      check("R8 command word reads zero", d, 32'h0);
    end
    rd(mbox_a(1), d);
    check("R8 reserved bit zero", 32'(d[31]), 32'h0);
  endtask

  task automatic t_mbox_write();
    wr(mbox_a(1), 32'hFFFF_FFFF);
    wr(mbox_a(3), 32'h4000_0000);
    chk_mbox("R9 mailbox write ignored", 1, mbox_v(0, 16'h0101));
    chk_mbox("R9 no pending created", 3, 32'h0);
    chk_irq("R9 irq unchanged", 4'b0010);
  endtask

  task automatic t_reset_mid();
    wr(cmd_a(2), cmd_w(0, 1, 3, 16'hC0DE));
    chk_irq("R2 setup before reset", 4'b1010);
    do_reset();
    t_reset_state();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_basic_send();
    t_overwrite();
    t_ack();
    t_bad_target();
    t_ack_send();
    t_reads();
    t_mbox_write();
    t_reset_mid();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule